// File: doc/BRIEF.md
# Width-Packing DMA Channel FIFO

This block sits inside one DMA channel between a narrow source side and a wider destination side. Source beats of 1, 2 or 4 bytes enter a 16-byte ring and are handed out as destination words of 1, 2 or 4 bytes. Bytes keep their arrival order, and the earliest byte goes in the lowest lane. Bus protocols, address generation and descriptor chaining live elsewhere. This block only holds bytes, repacks them and answers the channel controls.

Three controls shape the data path. Suspend halts intake. Complete words still drain while suspended, and the empty flag then rises as soon as the bytes left cannot fill one destination word, even though those bytes are still stored. Deasserting suspend keeps those bytes, and packing carries on with no loss. Disable throws away everything stored, including such a remainder, and sends none of it. A block-complete pulse starts a flush instead: the remainder leaves as a partial word with a byte-valid mask, and the ring ends up empty. A free-running counter records every source beat accepted, including beats whose bytes are later thrown away.

Top module: `wpack_fifo`

## Requirements
- R1: After reset the fill level is 0, the beat count is 0, `fifo_empty` is 1, `dst_valid` is 0 and `src_ready` is 1.
- R2: Width code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 both mean 4 bytes. Source beats are packed little-endian: the first byte accepted appears on `dst_data[7:0]` and later bytes on higher lanes.
- R3: When the fill level is at least the destination width, `dst_valid` is 1 and `dst_bmask` has its low destination-width bits set. A cycle with `dst_ready` high removes that many bytes.
- R4: `src_ready` is 0 whenever the fill level plus the source width would exceed 16 bytes. The fill level never exceeds 16, and stored bytes are not overwritten.
- R5: While `suspend` is 1, `src_ready` is 0. Complete destination words are still delivered.
- R6: With `suspend` at 0, `fifo_empty` is 1 exactly when the fill level is 0. With `suspend` at 1, `fifo_empty` is 1 once the fill level is below the destination width.
- R7: If `suspend` returns to 0 without a disable, the held bytes are kept, and later beats pack behind them with no gap.
- R8: A cycle with `disable_ch` high discards all stored bytes. From the next cycle the fill level is 0 and `dst_valid` is 0, and none of the discarded bytes is ever output.
- R9: `beat_count` rises by one for each cycle with `src_valid` and `src_ready` both high. It is not reduced when bytes are discarded.
- R10: A `block_done` pulse starts a flush. While flushing, `src_ready` is 0, and a remainder below the destination width is output as one word whose `dst_bmask` has its low fill-level bits set, with the unused lanes of `dst_data` at zero. After that word is taken the fill level is 0, and intake resumes one cycle later.
- R11: `fill_level` equals the bytes accepted minus the bytes delivered or discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_wcode | input | 2 | Source beat width code |
| dst_wcode | input | 2 | Destination word width code |
| src_valid | input | 1 | Source beat offered |
| src_data | input | 32 | Source beat, low lanes used |
| src_ready | output | 1 | Beat accepted this cycle if valid |
| dst_ready | input | 1 | Destination takes the offered word |
| dst_valid | output | 1 | A word is offered |
| dst_data | output | 32 | Offered word, unused lanes zero |
| dst_bmask | output | 4 | Valid byte lanes of the offered word |
| suspend | input | 1 | Channel suspend |
| disable_ch | input | 1 | Channel disable, discards contents |
| block_done | input | 1 | Block-complete pulse, starts flush |
| fifo_empty | output | 1 | Empty indication (see R6) |
| fill_level | output | 5 | Stored bytes |
| beat_count | output | 16 | Source beats accepted since reset |

## Verification
The assertions assume the width codes stay constant while bytes are stored. A width change with a non-empty ring would make the mask and level relations ambiguous. They also assume `block_done` and `disable_ch` are single-cycle pulses that are never raised together. The stimulus changes width codes only after the ring has been drained or discarded, and it raises each control pulse alone for one cycle. Suspend is held across several cycles so that the drain-then-hold behaviour can be observed.

// File: rtl/wpack_pkg.sv
package wpack_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int BUS_W   = LANES * LANE_W;
    localparam int LANE_CW = $clog2(LANES + 1);

    typedef enum logic [1:0] {
        WC_BYTE = 2'd0,
        WC_HALF = 2'd1,
        WC_WORD = 2'd2,
        WC_WIDE = 2'd3
    } wcode_e;

    typedef logic [LANE_CW-1:0] lanes_t;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic [LANES-1:0] mask;
    } dword_t;

    function automatic lanes_t code_bytes(input logic [1:0] code);
        case (wcode_e'(code))
            WC_BYTE: return lanes_t'(1);
            WC_HALF: return lanes_t'(2);
            default: return lanes_t'(LANES);
        endcase
    endfunction

    function automatic logic [LANES-1:0] low_mask(input lanes_t n);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) m[i] = (lanes_t'(i) < n);
        return m;
    endfunction
endpackage

// File: rtl/wpack_ring.sv
module wpack_ring
    import wpack_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       push,
    input  lanes_t                     push_n,
    input  logic [BUS_W-1:0]           push_data,
    input  logic                       pop,
    input  lanes_t                     pop_n,
    output logic [BUS_W-1:0]           head,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [LANE_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_q, rd_q;
    logic [CW-1:0]     level_q;
    logic [CW-1:0]     add_n, sub_n;

    assign add_n = push ? CW'(push_n) : '0;
    assign sub_n = pop  ? CW'(pop_n)  : '0;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_q    <= '0;
            rd_q    <= '0;
            level_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + PW'(push_n);
            if (pop)  rd_q <= rd_q + PW'(pop_n);
            level_q <= level_q + add_n - sub_n;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (push && !clear && !rst && (lanes_t'(i) < push_n))
                mem[wr_q + PW'(i)] <= push_data[i*LANE_W +: LANE_W];
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_head
        assign head[g*LANE_W +: LANE_W] = mem[rd_q + PW'(g)];
    end

    assign level = level_q;
endmodule

// File: rtl/wpack_ctrl.sv
module wpack_ctrl
    import wpack_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(DEPTH+1)-1:0] level,
    input  lanes_t                     sbytes,
    input  lanes_t                     dbytes,
    input  logic                       src_valid,
    input  logic                       dst_ready,
    input  logic                       suspend,
    input  logic                       disable_ch,
    input  logic                       block_done,
    output logic                       src_ready,
    output logic                       push,
    output logic                       dst_valid,
    output logic                       pop,
    output lanes_t                     pop_n,
    output logic [LANES-1:0]           out_mask,
    output logic                       fifo_empty
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          flush_q;
    logic          full_word, partial, room;
    logic [CW:0]   after_push;

    assign full_word  = level >= CW'(dbytes);
    assign partial    = (level != '0) && !full_word;
    assign after_push = {1'b0, level} + (CW+1)'(sbytes);
    assign room       = after_push <= (CW+1)'(DEPTH);

    assign src_ready  = !suspend && !flush_q && !disable_ch && room;
    assign push       = src_valid && src_ready;

    assign dst_valid  = !disable_ch && (full_word || (flush_q && partial));
    assign pop_n      = full_word ? dbytes : lanes_t'(level);
    assign pop        = dst_valid && dst_ready;
    assign out_mask   = dst_valid ? low_mask(pop_n) : '0;

    assign fifo_empty = suspend ? !full_word : (level == '0);

    always_ff @(posedge clk) begin
        if (rst || disable_ch)           flush_q <= 1'b0;
        else if (block_done)             flush_q <= 1'b1;
        else if (flush_q && level == '0) flush_q <= 1'b0;
    end
endmodule

// File: rtl/wpack_beats.sv
module wpack_beats #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (inc) count <= count + W'(1);
    end
endmodule

// File: rtl/wpack_fifo.sv
module wpack_fifo
    import wpack_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int BEAT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [1:0]                 src_wcode,
    input  logic [1:0]                 dst_wcode,
    input  logic                       src_valid,
    input  logic [BUS_W-1:0]           src_data,
    output logic                       src_ready,
    input  logic                       dst_ready,
    output logic                       dst_valid,
    output logic [BUS_W-1:0]           dst_data,
    output logic [LANES-1:0]           dst_bmask,
    input  logic                       suspend,
    input  logic                       disable_ch,
    input  logic                       block_done,
    output logic                       fifo_empty,
    output logic [$clog2(DEPTH+1)-1:0] fill_level,
    output logic [BEAT_W-1:0]          beat_count
);
    localparam int CW = $clog2(DEPTH + 1);

    lanes_t           sbytes, dbytes, pop_n;
    logic             push, pop;
    logic [BUS_W-1:0] head;
    logic [CW-1:0]    level;
    dword_t           word;

    assign sbytes = code_bytes(src_wcode);
    assign dbytes = code_bytes(dst_wcode);

    wpack_ring #(.DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .clear     (disable_ch),
        .push      (push),
        .push_n    (sbytes),
        .push_data (src_data),
        .pop       (pop),
        .pop_n     (pop_n),
        .head      (head),
        .level     (level)
    );

    wpack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .level      (level),
        .sbytes     (sbytes),
        .dbytes     (dbytes),
        .src_valid  (src_valid),
        .dst_ready  (dst_ready),
        .suspend    (suspend),
        .disable_ch (disable_ch),
        .block_done (block_done),
        .src_ready  (src_ready),
        .push       (push),
        .dst_valid  (dst_valid),
        .pop        (pop),
        .pop_n      (pop_n),
        .out_mask   (word.mask),
        .fifo_empty (fifo_empty)
    );

    wpack_beats #(.W(BEAT_W)) u_beats (
        .clk   (clk),
        .rst   (rst),
        .inc   (push),
        .count (beat_count)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word.data[g*LANE_W +: LANE_W] =
            word.mask[g] ? head[g*LANE_W +: LANE_W] : '0;
    end

    assign dst_data   = word.data;
    assign dst_bmask  = word.mask;
    assign fill_level = level;
endmodule

// File: rtl/wpack_fifo_chk.sv
module wpack_fifo_chk
    import wpack_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int BEAT_W = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       src_valid,
    input logic                       src_ready,
    input logic                       dst_valid,
    input logic [LANES-1:0]           dst_bmask,
    input logic                       suspend,
    input logic                       disable_ch,
    input logic                       block_done,
    input logic                       fifo_empty,
    input logic [$clog2(DEPTH+1)-1:0] fill_level,
    input logic [BEAT_W-1:0]          beat_count
);
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill_level <= ($clog2(DEPTH+1))'(DEPTH)); // R4
    AST_SUSPEND_NO_INTAKE: assert property (@(posedge clk) disable iff (rst)
        suspend |-> !src_ready); // R5
    AST_EMPTY_NO_WORD: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty && !suspend) |-> !dst_valid); // R6
    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (suspend && !dst_valid && !disable_ch && !block_done) |=> $stable(fill_level)); // R7
    AST_DISABLE_DROP: assert property (@(posedge clk) disable iff (rst)
        disable_ch |=> (fill_level == '0) && !dst_valid); // R8
    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        (src_valid && src_ready) |=> beat_count == $past(beat_count) + BEAT_W'(1)); // R9
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(src_valid && src_ready) |=> $stable(beat_count)); // R9
    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (rst)
        dst_valid |-> (dst_bmask != '0) &&
                      ($countones({1'b0, dst_bmask} + (LANES+1)'(1)) == 1)); // R10
endmodule

bind wpack_fifo wpack_fifo_chk #(.DEPTH(DEPTH), .BEAT_W(BEAT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_valid  (src_valid),
    .src_ready  (src_ready),
    .dst_valid  (dst_valid),
    .dst_bmask  (dst_bmask),
    .suspend    (suspend),
    .disable_ch (disable_ch),
    .block_done (block_done),
    .fifo_empty (fifo_empty),
    .fill_level (fill_level),
    .beat_count (beat_count)
);

// File: tb/test_wpack_fifo.sv
module test_wpack_fifo;
    localparam int CLK_P = 10;
    localparam int NV    = 8;
    // {src code, dst code, beats}
    localparam logic [7:0] VEC [NV] = '{
        8'h28, 8'h64, 8'h16, 8'hA3, 8'h82, 8'h43, 8'h92, 8'hE2
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  src_wcode = 2'd0, dst_wcode = 2'd0;
    logic        src_valid = 1'b0, dst_ready = 1'b0;
    logic [31:0] src_data = '0;
    logic        suspend = 1'b0, disable_ch = 1'b0, block_done = 1'b0;
    logic        src_ready, dst_valid, fifo_empty;
    logic [31:0] dst_data;
    logic [3:0]  dst_bmask;
    logic [4:0]  fill_level;
    logic [15:0] beat_count;

    int n_chk = 0, n_fail = 0, exp_beats = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    wpack_fifo i_wpack_fifo (
        .clk(clk), .rst(rst), .src_wcode(src_wcode), .dst_wcode(dst_wcode),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .dst_ready(dst_ready), .dst_valid(dst_valid), .dst_data(dst_data),
        .dst_bmask(dst_bmask), .suspend(suspend), .disable_ch(disable_ch),
        .block_done(block_done), .fifo_empty(fifo_empty),
        .fill_level(fill_level), .beat_count(beat_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    task automatic idle();
        @(negedge clk);
        src_valid = 1'b0; dst_ready = 1'b0; block_done = 1'b0; disable_ch = 1'b0;
        #1;
    endtask

    task automatic push_beat(input logic [31:0] d);
        @(negedge clk);
        dst_ready = 1'b0; block_done = 1'b0; disable_ch = 1'b0;
        src_valid = 1'b1; src_data = d;
        #1;
        if (src_ready) exp_beats++;
    endtask

    task automatic pop_word(input string req, input logic [31:0] ed, input logic [3:0] em);
        @(negedge clk);
        src_valid = 1'b0; block_done = 1'b0; disable_ch = 1'b0; dst_ready = 1'b1;
        #1;
        chk({req, " valid"}, {31'd0, dst_valid}, 32'd1);
        chk({req, " data"}, dst_data, ed);
        chk({req, " mask"}, {28'd0, dst_bmask}, {28'd0, em});
    endtask

    task automatic pulse_ctrl(input bit dis, input bit done);
        @(negedge clk);
        src_valid = 1'b0; dst_ready = 1'b0; disable_ch = dis; block_done = done;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 fill", {27'd0, fill_level}, 32'd0);
        chk("R1 beats", {16'd0, beat_count}, 32'd0);
        chk("R1 empty", {31'd0, fifo_empty}, 32'd1);
        chk("R1 valid", {31'd0, dst_valid}, 32'd0);
        chk("R1 ready", {31'd0, src_ready}, 32'd1);

        // R2 R3 R11 packing table
        for (int k = 0; k < NV; k++) begin
            automatic int sb = nbytes(VEC[k][7:6]);
            automatic int db = nbytes(VEC[k][5:4]);
            automatic int nb = int'(VEC[k][3:0]);
            automatic int total = sb * nb;
            @(negedge clk);
            src_wcode = VEC[k][7:6]; dst_wcode = VEC[k][5:4];
            for (int b = 0; b < nb; b++) begin
                automatic logic [31:0] d = 32'hEEEE_EEEE;
                for (int l = 0; l < sb; l++) d[l*8 +: 8] = {4'(k), 4'(b*sb + l)};
                push_beat(d);
            end
            idle();
            chk("R11 level after packing", {27'd0, fill_level}, 32'(total));
            for (int w = 0; w < total / db; w++) begin
                automatic logic [31:0] ed = '0;
                automatic logic [3:0]  em = '0;
                for (int l = 0; l < db; l++) begin
                    ed[l*8 +: 8] = {4'(k), 4'(w*db + l)};
                    em[l] = 1'b1;
                end
                pop_word("R2 R3 word", ed, em);
            end
            idle();
            chk("R6 empty after drain", {31'd0, fifo_empty}, 32'd1);
            chk("R9 beats", {16'd0, beat_count}, 32'(exp_beats));
        end

        // R4 overflow
        @(negedge clk); src_wcode = 2'd2; dst_wcode = 2'd2;
        for (int b = 0; b < 4; b++) push_beat({4{8'(8'h50 + b)}});
        push_beat(32'hDEAD_BEEF);
        chk("R4 ready when full", {31'd0, src_ready}, 32'd0);
        idle();
        chk("R4 level capped", {27'd0, fill_level}, 32'd16);
        chk("R9 beats after full", {16'd0, beat_count}, 32'(exp_beats));
        pop_word("R4 first word intact", 32'h5050_5050, 4'hF);
        // R8 disable discards
        pulse_ctrl(1'b1, 1'b0);
        idle();
        chk("R8 level after disable", {27'd0, fill_level}, 32'd0);
        chk("R8 valid after disable", {31'd0, dst_valid}, 32'd0);
        chk("R9 beats kept after disable", {16'd0, beat_count}, 32'(exp_beats));

        // R5 R6 R7 suspend and resume
        @(negedge clk); src_wcode = 2'd0; dst_wcode = 2'd2;
        for (int b = 0; b < 6; b++) push_beat(32'(8'h10 + b));
        idle();
        suspend = 1'b1;
        #1;
        chk("R5 no intake suspended", {31'd0, src_ready}, 32'd0);
        chk("R6 not empty with word", {31'd0, fifo_empty}, 32'd0);
        pop_word("R5 drain while suspended", 32'h1312_1110, 4'hF);
        idle();
        chk("R6 empty with remainder", {31'd0, fifo_empty}, 32'd1);
        chk("R6 remainder held", {27'd0, fill_level}, 32'd2);
        chk("R6 no partial offered", {31'd0, dst_valid}, 32'd0);
        idle();
        chk("R7 held over cycles", {27'd0, fill_level}, 32'd2);
        suspend = 1'b0;
        push_beat(32'h16);
        push_beat(32'h17);
        pop_word("R7 resume no loss", 32'h1716_1514, 4'hF);
        idle();

        // R8 disable with suspended remainder
        for (int b = 0; b < 3; b++) push_beat(32'(8'h20 + b));
        idle();
        suspend = 1'b1;
        #1;
        chk("R6 empty with 3 bytes", {31'd0, fifo_empty}, 32'd1);
        pulse_ctrl(1'b1, 1'b0);
        idle();
        suspend = 1'b0;
        #1;
        chk("R8 remainder dropped", {27'd0, fill_level}, 32'd0);
        chk("R9 dropped beats counted", {16'd0, beat_count}, 32'(exp_beats));
        for (int b = 0; b < 4; b++) push_beat(32'(8'h30 + b));
        pop_word("R8 no stale bytes", 32'h3332_3130, 4'hF);
        idle();

        // R10 flush at block completion
        for (int b = 0; b < 6; b++) push_beat(32'(8'h40 + b));
        pulse_ctrl(1'b0, 1'b1);
        idle();
        chk("R10 intake blocked in flush", {31'd0, src_ready}, 32'd0);
        pop_word("R10 full word in flush", 32'h4342_4140, 4'hF);
        pop_word("R10 partial word", 32'h0000_4544, 4'h3);
        idle();
        chk("R10 level cleared", {27'd0, fill_level}, 32'd0);
        chk("R10 nothing offered", {31'd0, dst_valid}, 32'd0);
        chk("R6 empty after flush", {31'd0, fifo_empty}, 32'd1);
        idle();
        chk("R10 intake resumes", {31'd0, src_ready}, 32'd1);
        chk("R9 final beats", {16'd0, beat_count}, 32'(exp_beats));

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule